// File: doc/BRIEF.md
# Multi-Mode Display Bus Master

This block is the master side of a parallel bus toward character display modules or small peripherals that take commands and data over a strobed bus. A 3-bit mode input selects the signalling. The modes are a character-module bus with 4-bit or 8-bit data, a 6800-style bus with an enable clock and a read/write line, or an 8080-style bus with separate active-low read and write strobes. The 6800-style and 8080-style buses also have variants with a synchronous clock. The same five control pins carry different meanings in each mode.

A client issues one transfer at a time through a valid/ready request. Each request carries a command/data flag, a read/write flag, a device number (0 or 1) and up to 16 bits of write data. The controller steps through setup, strobe and hold phases. The length of each phase comes from the timing word of the selected device. One cycle after the hold phase it pulses a response, together with the read data for reads.

Top module: `dispbus_ctrl`

## Requirements
- R1: After reset no transfer is in progress. With mode 100 applied, the pins are: `req_ready`=1, `rsp_valid`=0, `bus_rs`=0, `bus_rw_wrn`=1, `bus_e_rdn`=0, `bus_cs0`=0, `bus_cs1`=0, `bus_sclk`=0 and `bus_doe`=0.
- R2: In mode 100 (character-module bus), the pins are used as follows.
  - `bus_rw_wrn` is the read/write line (1 = read).
  - `bus_e_rdn` is the high-active enable of device 0.
  - `bus_cs0` is the high-active enable of device 1.
  - `bus_cs1` stays 0.
  - Only the addressed device's enable pulses.
- R3: In modes 001 and 000 (6800-style), `bus_e_rdn` is the high-active enable clock and `bus_rw_wrn` is the read/write line (1 = read). `bus_cs0` and `bus_cs1` are active-low selects. The addressed device's select stays low from setup through hold, and the other select stays high.
- R4: In modes 011 and 010 (8080-style), `bus_rw_wrn` is an active-low write strobe and `bus_e_rdn` is an active-low read strobe. Only the strobe that matches the transfer direction pulses. The selects behave as in R3, and when idle all four control pins are high.
- R5: `bus_rs` is 0 for a command and 1 for data. It is held steady for the whole transfer.
- R6: A device timing word holds the setup count in bits [3:0], the strobe count in bits [9:4] and the hold count in bits [13:10]. Each phase lasts its count plus one clock, and `rsp_valid` is high for exactly one clock right after the hold phase. The first setup cycle follows the accepting clock edge, so a single strobe ends with `rsp_valid` S+W+H+3 cycles after the first setup cycle.
- R7: A transfer to device 0 is timed by `cfg_dev0`, and a transfer to device 1 is timed by `cfg_dev1`.
- R8: In mode 100 with `char_4bit`=1, each byte moves as two strobes. The upper nibble goes first, on data lines [7:4], and lines [3:0] are 0. A read assembles the first captured nibble (taken from `bus_din[7:4]`) into result bits [7:4] and the second into bits [3:0].
- R9: In 8-bit character mode, `bus_dout[7:0]` carries the write byte and the upper lines are 0. In 6800-style and 8080-style modes all 16 lines carry the write word.
- R10: During a read, `bus_doe` stays 0. The data is sampled on the last clock of the strobe phase and returned on `rsp_rdata`, using the same lane rules as R8 and R9.
- R11: In modes 000 and 010, `bus_sclk` toggles every clock while a transfer is in progress. In all other modes it stays 0, and it is 0 once the block has been idle for a cycle.
- R12: Mode codes 101, 110 and 111 are reserved. With one of them applied, `req_ready` stays 0, no transfer starts and no response appears.
- R13: `req_ready` is 1 only while idle. A request held asserted during a transfer is not taken again, so exactly one response is produced per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Bus signalling mode |
| char_4bit | input | 1 | 4-bit data in character-module mode |
| cfg_dev0 | input | 14 | Timing word of device 0 |
| cfg_dev1 | input | 14 | Timing word of device 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_is_data | input | 1 | 1 = data, 0 = command |
| req_read | input | 1 | 1 = read, 0 = write |
| req_dev | input | 1 | Target device |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Transfer complete pulse |
| rsp_rdata | output | 16 | Read result |
| bus_rs | output | 1 | Register select |
| bus_rw_wrn | output | 1 | Read/write line or write strobe (mode dependent) |
| bus_e_rdn | output | 1 | Enable of device 0, enable clock, or read strobe |
| bus_cs0 | output | 1 | Enable of device 1, or select of device 0 |
| bus_cs1 | output | 1 | Select of device 1 |
| bus_sclk | output | 1 | Synchronous bus clock |
| bus_dout | output | 16 | Data toward the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 16 | Data from the bus |

## Verification
Two events share a clock edge in this block.

The first pair is the read capture on the last strobe clock and the change into the hold phase. The bench's device model drives the correct read value only in that final strobe clock and the complement in every other strobe clock, so a capture that is one cycle early or late returns the complement.

The second pair is a response and a still-asserted request. The driver keeps `req_valid` high until it sees the response. A controller that re-accepts the request during the transfer or on its completion cycle produces an unexpected response or a wrong latency, and the scoreboard reports it.

// File: rtl/dispbus_pkg.sv
package dispbus_pkg;

    localparam int SETUP_W = 4;
    localparam int STRB_W  = 6;
    localparam int HOLD_W  = 4;
    localparam int CFG_W   = SETUP_W + STRB_W + HOLD_W;
    localparam int CNT_W   = STRB_W;

    typedef enum logic [2:0] {
        MD_SYNC_M68 = 3'b000,
        MD_M68      = 3'b001,
        MD_SYNC_I80 = 3'b010,
        MD_I80      = 3'b011,
        MD_CHAR     = 3'b100
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [HOLD_W-1:0]  hold;
        logic [STRB_W-1:0]  strobe;
        logic [SETUP_W-1:0] setup;
    } timing_t;

    function automatic logic mode_ok(input logic [2:0] m);
        return (m <= 3'b100);
    endfunction

    function automatic logic mode_sync(input mode_e m);
        return (m == MD_SYNC_M68) || (m == MD_SYNC_I80);
    endfunction

    function automatic logic mode_i80(input mode_e m);
        return (m == MD_I80) || (m == MD_SYNC_I80);
    endfunction

    function automatic logic mode_m68(input mode_e m);
        return (m == MD_M68) || (m == MD_SYNC_M68);
    endfunction

endpackage

// File: rtl/dispbus_phase_timer.sv
module dispbus_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/dispbus_data_lane.sv
module dispbus_data_lane #(
    parameter int DATA_W = 16
) (
    input  logic              is_char,
    input  logic              nib,
    input  logic              second,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rdata_q,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] rdata_next
);

    localparam int UPPER_W = DATA_W - 8;

    always_comb begin
        if (nib) begin
            dout = {{UPPER_W{1'b0}}, (second ? wdata[3:0] : wdata[7:4]), 4'b0000};
        end else if (is_char) begin
            dout = {{UPPER_W{1'b0}}, wdata[7:0]};
        end else begin
            dout = wdata;
        end
    end

    always_comb begin
        if (nib) begin
            if (second) begin
                rdata_next = {rdata_q[DATA_W-1:4], din[7:4]};
            end else begin
                rdata_next = {{UPPER_W{1'b0}}, din[7:4], 4'b0000};
            end
        end else if (is_char) begin
            rdata_next = {{UPPER_W{1'b0}}, din[7:0]};
        end else begin
            rdata_next = din;
        end
    end

endmodule

// File: rtl/dispbus_pin_map.sv
module dispbus_pin_map
    import dispbus_pkg::*;
(
    input  mode_e mode,
    input  logic  active,
    input  logic  strobe,
    input  logic  rd,
    input  logic  dev,
    input  logic  is_data,
    output logic  rs,
    output logic  rw_wrn,
    output logic  e_rdn,
    output logic  cs0,
    output logic  cs1
);

    logic sel0, sel1;

    assign sel0 = active && !dev;
    assign sel1 = active && dev;
    assign rs   = active && is_data;

    always_comb begin
        if (mode == MD_CHAR) begin
            rw_wrn = active ? rd : 1'b1;
            e_rdn  = strobe && !dev;
            cs0    = strobe && dev;
            cs1    = 1'b0;
        end else if (mode_i80(mode)) begin
            rw_wrn = !(strobe && !rd);
            e_rdn  = !(strobe && rd);
            cs0    = !sel0;
            cs1    = !sel1;
        end else begin
            rw_wrn = active ? rd : 1'b1;
            e_rdn  = strobe;
            cs0    = !sel0;
            cs1    = !sel1;
        end
    end

endmodule

// File: rtl/dispbus_ctrl.sv
module dispbus_ctrl
    import dispbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic              char_4bit,
    input  logic [CFG_W-1:0]  cfg_dev0,
    input  logic [CFG_W-1:0]  cfg_dev1,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_data,
    input  logic              req_read,
    input  logic              req_dev,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_rs,
    output logic              bus_rw_wrn,
    output logic              bus_e_rdn,
    output logic              bus_cs0,
    output logic              bus_cs1,
    output logic              bus_sclk,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din
);

    typedef struct packed {
        state_e            st;
        mode_e             mode;
        timing_t           tm;
        logic              is_data;
        logic              rd;
        logic              dev;
        logic              nib;
        logic              second;
        logic              sclk;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic [DATA_W-1:0] lane_rdata;
    logic             xfer_active;
    timing_t          pick_tm;

    state_e           cur_st;
    mode_e            cur_mode;
    logic             cur_rd;

    assign pick_tm     = req_dev ? timing_t'(cfg_dev1) : timing_t'(cfg_dev0);
    assign req_ready   = (c_q.st == ST_IDLE) && mode_ok(mode_sel);
    assign xfer_active = (c_q.st == ST_SETUP) || (c_q.st == ST_STROBE) || (c_q.st == ST_HOLD);

    always_comb begin
        c_d      = c_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (c_q.st)
            ST_IDLE: begin
                c_d.mode = mode_e'(mode_sel);
                if (req_valid && req_ready) begin
                    c_d.st      = ST_SETUP;
                    c_d.tm      = pick_tm;
                    c_d.is_data = req_is_data;
                    c_d.rd      = req_read;
                    c_d.dev     = req_dev;
                    c_d.wdata   = req_wdata;
                    c_d.nib     = (mode_sel == MD_CHAR) && char_4bit;
                    c_d.second  = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(pick_tm.setup);
                end
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    c_d.st   = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(c_q.tm.strobe);
                end
            end
            ST_STROBE: begin
                if (tmr_last) begin
                    c_d.st   = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(c_q.tm.hold);
                    if (c_q.rd) begin
                        c_d.rdata = lane_rdata;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_last) begin
                    if (c_q.nib && !c_q.second) begin
                        c_d.st     = ST_SETUP;
                        c_d.second = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = CNT_W'(c_q.tm.setup);
                    end else begin
                        c_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                c_d.st = ST_IDLE;
            end
            default: begin
                c_d.st = ST_IDLE;
            end
        endcase
        c_d.sclk = ((c_q.st != ST_IDLE) && mode_sync(c_q.mode)) ? !c_q.sclk : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, mode: MD_CHAR, tm: '0, is_data: 1'b0, rd: 1'b0,
                     dev: 1'b0, nib: 1'b0, second: 1'b0, sclk: 1'b0,
                     wdata: '0, rdata: '0};
        end else begin
            c_q <= c_d;
        end
    end

    dispbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    dispbus_data_lane #(.DATA_W(DATA_W)) u_lane (
        .is_char    (c_q.mode == MD_CHAR),
        .nib        (c_q.nib),
        .second     (c_q.second),
        .wdata      (c_q.wdata),
        .din        (bus_din),
        .rdata_q    (c_q.rdata),
        .dout       (bus_dout),
        .rdata_next (lane_rdata)
    );

    dispbus_pin_map u_pins (
        .mode    (c_q.mode),
        .active  (xfer_active),
        .strobe  (c_q.st == ST_STROBE),
        .rd      (c_q.rd),
        .dev     (c_q.dev),
        .is_data (c_q.is_data),
        .rs      (bus_rs),
        .rw_wrn  (bus_rw_wrn),
        .e_rdn   (bus_e_rdn),
        .cs0     (bus_cs0),
        .cs1     (bus_cs1)
    );

    assign bus_doe   = xfer_active && !c_q.rd;
    assign bus_sclk  = c_q.sclk;
    assign rsp_valid = (c_q.st == ST_DONE);
    assign rsp_rdata = c_q.rdata;

    assign cur_st   = c_q.st;
    assign cur_mode = c_q.mode;
    assign cur_rd   = c_q.rd;

endmodule

// File: rtl/dispbus_ctrl_chk.sv
module dispbus_ctrl_chk
    import dispbus_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_sel,
    input state_e     cur_st,
    input mode_e      cur_mode,
    input logic       cur_rd,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       bus_rs,
    input logic       bus_rw_wrn,
    input logic       bus_e_rdn,
    input logic       bus_cs0,
    input logic       bus_cs1,
    input logic       bus_sclk,
    input logic       bus_doe
);

    logic busy_now;
    assign busy_now = (cur_st == ST_SETUP) || (cur_st == ST_STROBE) || (cur_st == ST_HOLD);

    a_r12_reserved_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok(mode_sel) |-> !req_ready);

    a_r13_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cur_st == ST_IDLE));

    a_r6_single_response: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r10_float_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_now && cur_rd) |-> !bus_doe);

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i80(cur_mode) |-> (bus_rw_wrn || bus_e_rdn));

    a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i80(cur_mode) || mode_m68(cur_mode)) |-> (bus_cs0 || bus_cs1));

    a_r2_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MD_CHAR) |-> !(bus_e_rdn && bus_cs0));

    a_r5_rs_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_now && $past(busy_now)) |-> $stable(bus_rs));

    a_r11_sclk_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_IDLE && $past(cur_st == ST_IDLE)) |-> !bus_sclk);

endmodule

bind dispbus_ctrl dispbus_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .cur_st     (cur_st),
    .cur_mode   (cur_mode),
    .cur_rd     (cur_rd),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .bus_rs     (bus_rs),
    .bus_rw_wrn (bus_rw_wrn),
    .bus_e_rdn  (bus_e_rdn),
    .bus_cs0    (bus_cs0),
    .bus_cs1    (bus_cs1),
    .bus_sclk   (bus_sclk),
    .bus_doe    (bus_doe)
);

// File: tb/dispbus_ctrl_bench.sv
`timescale 1ns/1ps
module dispbus_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'b100;
    logic        char_4bit = 1'b0;
    logic [13:0] cfg_dev0 = '0;
    logic [13:0] cfg_dev1 = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_is_data = 1'b0;
    logic        req_read = 1'b0;
    logic        req_dev = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        bus_rs, bus_rw_wrn, bus_e_rdn, bus_cs0, bus_cs1, bus_sclk, bus_doe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    rsp_seen = 0;
    int    rsp_exp = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dispbus_ctrl u_dispbus_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .char_4bit(char_4bit),
        .cfg_dev0(cfg_dev0), .cfg_dev1(cfg_dev1),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_data(req_is_data),
        .req_read(req_read), .req_dev(req_dev), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_rs(bus_rs), .bus_rw_wrn(bus_rw_wrn), .bus_e_rdn(bus_e_rdn),
        .bus_cs0(bus_cs0), .bus_cs1(bus_cs1), .bus_sclk(bus_sclk),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    typedef struct {
        logic [2:0]  md;
        bit          dev, data, rd, nib, sync;
        int          s, w, h, pulses, start;
        logic [15:0] word0, word1, da, db, exp_rd;
        string       tag;
    } item_t;

    item_t sb_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit strobe_on(input item_t it);
        case (it.md)
            3'b100:         return it.dev ? bus_cs0 : bus_e_rdn;
            3'b011, 3'b010: return it.rd ? !bus_e_rdn : !bus_rw_wrn;
            default:        return bus_e_rdn;
        endcase
    endfunction

    // monitor state
    bit          strb_prev = 1'b0;
    int          strb_cnt = 0;
    int          pulses = 0;
    int          toggles = 0;
    bit          width_bad = 1'b0;
    bit          pin_bad = 1'b0;
    bit          busy_bad = 1'b0;
    logic [15:0] words [2];
    logic        sclk_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n && rsp_valid && sb_q.size() == 0) begin
            chk(1'b0, "R13 unexpected response", 1, 0);
        end else if (rst_n && sb_q.size() > 0) begin
            item_t it;
            bit    s;
            it = sb_q[0];
            s  = strobe_on(it);
            if (!rsp_valid && req_ready) busy_bad = 1'b1;
            if (it.md == 3'b100) begin
                if ((it.dev ? bus_e_rdn : bus_cs0) || bus_cs1) pin_bad = 1'b1;
            end
            if (s) begin
                strb_cnt++;
                if (pulses < 2) words[pulses] = bus_dout;
                if (bus_rs != it.data) pin_bad = 1'b1;
                if (bus_doe != !it.rd) pin_bad = 1'b1;
                if (it.md != 3'b100) begin
                    if ((it.dev ? bus_cs1 : bus_cs0) != 1'b0) pin_bad = 1'b1;
                    if ((it.dev ? bus_cs0 : bus_cs1) != 1'b1) pin_bad = 1'b1;
                end
                if (it.md == 3'b011 || it.md == 3'b010) begin
                    if ((it.rd ? bus_rw_wrn : bus_e_rdn) != 1'b1) pin_bad = 1'b1;
                end else begin
                    if (bus_rw_wrn != it.rd) pin_bad = 1'b1;
                end
                if (strb_cnt == it.w + 1) bus_din = (pulses == 0) ? it.da : it.db;
                else                       bus_din = ~((pulses == 0) ? it.da : it.db);
            end else begin
                if (strb_prev) begin
                    if (strb_cnt != it.w + 1) width_bad = 1'b1;
                    pulses++;
                    strb_cnt = 0;
                end
                bus_din = 16'h0000;
            end
            strb_prev = s;
            if (bus_sclk != sclk_prev) toggles++;
            if (rsp_valid) begin
                rsp_seen++;
                chk(cyc - it.start == it.pulses * (it.s + it.w + it.h + 3),
                    {"R6 latency ", it.tag}, cyc - it.start, it.pulses * (it.s + it.w + it.h + 3));
                chk(pulses == it.pulses, {"R8 strobe count ", it.tag}, pulses, it.pulses);
                chk(!width_bad, {"R7 strobe width ", it.tag}, width_bad, 0);
                chk(!pin_bad, {"R2 R3 R4 R5 pin roles ", it.tag}, pin_bad, 0);
                chk(!busy_bad, {"R13 ready while busy ", it.tag}, busy_bad, 0);
                chk((toggles != 0) == it.sync, {"R11 sync clock ", it.tag}, toggles, it.sync);
                if (it.rd) begin
                    chk(rsp_rdata == it.exp_rd, {"R10 read data ", it.tag}, rsp_rdata, it.exp_rd);
                end else begin
                    chk(words[0] == it.word0, {"R9 write lanes ", it.tag}, words[0], it.word0);
                    if (it.nib) chk(words[1] == it.word1, {"R8 low nibble ", it.tag}, words[1], it.word1);
                end
                void'(sb_q.pop_front());
                pulses = 0; strb_cnt = 0; toggles = 0;
                width_bad = 0; pin_bad = 0; busy_bad = 0; strb_prev = 0;
            end
        end
        sclk_prev = bus_sclk;
    end

    task automatic run_xfer(input string tag, input logic [2:0] md, input bit nib, input bit dev,
                            input bit data, input bit rd, input logic [15:0] wd,
                            input logic [15:0] da, input logic [15:0] db);
        item_t       it;
        logic [13:0] cf;
        mode_sel  = md;
        char_4bit = nib;
        repeat (2) @(negedge clk);
        cf = dev ? cfg_dev1 : cfg_dev0;
        it.tag = tag; it.md = md; it.dev = dev; it.data = data; it.rd = rd;
        it.nib = (md == 3'b100) && nib;
        it.sync = (md == 3'b000) || (md == 3'b010);
        it.s = int'(cf[3:0]); it.w = int'(cf[9:4]); it.h = int'(cf[13:10]);
        it.pulses = it.nib ? 2 : 1;
        it.da = da; it.db = db;
        if (it.nib) begin
            it.word0  = {8'h00, wd[7:4], 4'h0};
            it.word1  = {8'h00, wd[3:0], 4'h0};
            it.exp_rd = {8'h00, da[7:4], db[7:4]};
        end else if (md == 3'b100) begin
            it.word0  = {8'h00, wd[7:0]};
            it.word1  = '0;
            it.exp_rd = {8'h00, da[7:0]};
        end else begin
            it.word0  = wd;
            it.word1  = '0;
            it.exp_rd = da;
        end
        req_dev = dev; req_is_data = data; req_read = rd; req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        it.start = cyc;
        sb_q.push_back(it);
        rsp_exp++;
        // request stays asserted through the transfer (R13 stress)
        do @(negedge clk); while (!rsp_valid);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values with mode 100
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 ready/rsp in reset", {req_ready, rsp_valid}, 2'b10);
        chk({bus_rs, bus_rw_wrn, bus_e_rdn, bus_cs0, bus_cs1, bus_sclk, bus_doe} == 7'b0100000,
            "R1 pins in reset", {bus_rs, bus_rw_wrn, bus_e_rdn, bus_cs0, bus_cs1, bus_sclk, bus_doe}, 7'b0100000);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_dev0 = {4'd1, 6'd3, 4'd2};
        cfg_dev1 = {4'd2, 6'd5, 4'd1};
        run_xfer("char8 cmd dev0",  3'b100, 0, 0, 0, 0, 16'hBE5A, 0, 0);
        run_xfer("char8 data dev1", 3'b100, 0, 1, 1, 0, 16'h12C3, 0, 0);
        run_xfer("char4 write",     3'b100, 1, 0, 1, 0, 16'h00A7, 0, 0);
        run_xfer("char4 read",      3'b100, 1, 1, 0, 1, 0, 16'h00D0, 16'h0060);
        run_xfer("char8 read",      3'b100, 0, 0, 1, 1, 0, 16'h5A3C, 0);
        run_xfer("m68 write dev1",  3'b001, 0, 1, 1, 0, 16'hF00D, 0, 0);
        run_xfer("m68 read dev0",   3'b001, 0, 0, 0, 1, 0, 16'hC0DE, 0);
        run_xfer("i80 write dev0",  3'b011, 0, 0, 1, 0, 16'h8421, 0, 0);
        run_xfer("i80 read dev1",   3'b011, 0, 1, 1, 1, 0, 16'h7E81, 0);
        run_xfer("sync m68 write",  3'b000, 0, 0, 0, 0, 16'h3C3C, 0, 0);
        run_xfer("sync i80 read",   3'b010, 0, 1, 0, 1, 0, 16'h9AB5, 0);
        cfg_dev0 = 14'd0;
        run_xfer("i80 zero timing", 3'b011, 0, 0, 1, 0, 16'h0F0F, 0, 0);
        run_xfer("m68 zero timing read", 3'b001, 0, 0, 1, 1, 0, 16'h1234, 0);

        // R4: idle levels in 8080 mode
        mode_sel = 3'b011;
        repeat (2) @(negedge clk);
        chk({bus_rw_wrn, bus_e_rdn, bus_cs0, bus_cs1} == 4'b1111, "R4 idle pins",
            {bus_rw_wrn, bus_e_rdn, bus_cs0, bus_cs1}, 4'b1111);
        chk(bus_sclk == 1'b0, "R11 sclk idle", bus_sclk, 0);

        // R12: reserved mode code
        mode_sel = 3'b110;
        req_valid = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            chk(req_ready == 1'b0 && rsp_valid == 1'b0 && bus_doe == 1'b0, "R12 reserved mode",
                {req_ready, rsp_valid, bus_doe}, 3'b000);
            @(negedge clk);
        end
        req_valid = 1'b0;
        mode_sel = 3'b100;
        repeat (4) @(negedge clk);
        chk(rsp_seen == rsp_exp && sb_q.size() == 0, "R13 response count", rsp_seen, rsp_exp);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule